// File: doc/BRIEF.md
# Tick Stream Slip Generator

This block moves the phase of a 100 kHz tick stream forward or backward, one tick at a time, so that a path timer fed by that stream can be pulled into step with a distant reference. The incoming stream is a single-clock enable pulse every `CLKS_PER_TICK` system clocks. An internal rate divider counts those ticks and raises a slip event at one of four selectable rates. Each event either adds a narrow tick or removes one.

With the advance command held, each slip event adds one extra tick midway between two real ticks, and the timer downstream runs ahead by one tick. With the retard command held, each event is latched and blanks the next real tick, and the timer falls back by one tick. The edited stream goes only to the path named by the path select. Every other path receives the untouched stream, and all outputs are registered.

Top module: `tick_slip_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge with `rst` high, every bit of `path_tick` is 0.
- R2: With `adv_cmd` and `ret_cmd` both low, every path output repeats `tick_in` exactly one clock later, one clock wide.
- R3: With `adv_cmd` and `ret_cmd` both high, every path output repeats `tick_in` one clock later, the same as in R2.
- R4: In advance mode (`adv_cmd`=1, `ret_cmd`=0), the input tick that completes each slip interval is followed, on the selected path, by one extra single-clock tick exactly `INSERT_AT` clocks after that tick's output.
- R5: In retard mode (`ret_cmd`=1, `adv_cmd`=0), the input tick that completes each slip interval arms a cancel. The next input tick is then absent from the selected path, and only that one tick is removed.
- R6: Every path whose index differs from `path_sel` carries `tick_in` delayed by one clock, whatever the commands and rate.
- R7: `rate_sel` sets the slip interval in input ticks: 0 gives `TICKS_PER_SEC`, 1 gives `TICKS_PER_SEC/10`, 2 gives `TICKS_PER_SEC/100` and 3 gives `TICKS_PER_SEC/1000`. After reset, the first event falls on the interval-th tick.
- R8: `path_sel` is a binary path index. A value of `NUM_PATHS` or more selects no path, and all outputs then follow R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Nominal tick enable, one clock wide |
| rate_sel | input | 2 | Slip rate code (R7) |
| adv_cmd | input | 1 | Advance command |
| ret_cmd | input | 1 | Retard command |
| path_sel | input | SEL_W | Index of the path to edit |
| path_tick | output | NUM_PATHS | Registered tick enable for each path |

## Verification
The scoreboard predicts each cycle's output vector. It covers the interval boundary where the Nth tick arms an event, the midpoint placement of an added tick, and the single tick that a retard event may remove. A rate divider that is off by one would shift every edit by a whole tick. An insertion counted from the wrong register stage would land one clock early or late. A cancel that stays armed would remove a run of ticks rather than one. Runs with both commands high, with a slower rate code, and with an out-of-range path index catch a decoder that treats conflicting commands as a direction, a rate table that is wrong, and steering that leaks edits onto another path.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  typedef enum logic [1:0] {
    SLIP_HOLD = 2'd0,
    SLIP_ADV  = 2'd1,
    SLIP_RET  = 2'd2
  } slip_mode_e;

  // Conflicting or absent commands leave the stream untouched.
  function automatic slip_mode_e decode_mode(input logic adv, input logic ret);
    if (adv && !ret) return SLIP_ADV;
    if (ret && !adv) return SLIP_RET;
    return SLIP_HOLD;
  endfunction

endpackage

// File: rtl/tsg_rate_div.sv
module tsg_rate_div #(
  parameter int TICKS_PER_SEC = 100000,
  localparam int CNT_W = $clog2(TICKS_PER_SEC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic [1:0] rate_sel,
  output logic       slip_due
);

  localparam int DIV1 = TICKS_PER_SEC;
  localparam int DIV2 = (TICKS_PER_SEC / 10   > 0) ? TICKS_PER_SEC / 10   : 1;
  localparam int DIV3 = (TICKS_PER_SEC / 100  > 0) ? TICKS_PER_SEC / 100  : 1;
  localparam int DIV4 = (TICKS_PER_SEC / 1000 > 0) ? TICKS_PER_SEC / 1000 : 1;

  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    unique case (rate_sel)
      2'd0:    last_idx = CNT_W'(DIV1 - 1);
      2'd1:    last_idx = CNT_W'(DIV2 - 1);
      2'd2:    last_idx = CNT_W'(DIV3 - 1);
      default: last_idx = CNT_W'(DIV4 - 1);
    endcase
  end

  // A rate change to a shorter interval wraps at once instead of overrunning.
  assign slip_due = tick_in && (tick_cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
    end else if (tick_in) begin
      tick_cnt <= slip_due ? '0 : tick_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tsg_edit.sv
module tsg_edit
  import tsg_pkg::*;
#(
  parameter int CLKS_PER_TICK = 1000,
  parameter int INSERT_AT     = CLKS_PER_TICK / 2,
  localparam int PH_W = $clog2(CLKS_PER_TICK + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic slip_due,
  input  logic adv_cmd,
  input  logic ret_cmd,
  output logic edited
);

  localparam logic [PH_W-1:0] PH_MAX = PH_W'(CLKS_PER_TICK);
  localparam logic [PH_W-1:0] PH_INS = PH_W'(INSERT_AT - 1);

  slip_mode_e       mode;
  logic [PH_W-1:0]  phase;
  logic             pend_adv;
  logic             pend_ret;
  logic             insert_now;

  assign mode       = decode_mode(adv_cmd, ret_cmd);
  assign insert_now = pend_adv && !tick_in && (phase == PH_INS);
  assign edited     = (tick_in && !pend_ret) || insert_now;

  // Clocks elapsed since the last real tick, parked at the top after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_MAX;
    end else if (tick_in) begin
      phase <= '0;
    end else if (phase != PH_MAX) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_adv <= 1'b0;
      pend_ret <= 1'b0;
    end else begin
      if (slip_due && mode == SLIP_ADV) begin
        pend_adv <= 1'b1;
      end else if (insert_now) begin
        pend_adv <= 1'b0;
      end
      if (tick_in) begin
        pend_ret <= slip_due && (mode == SLIP_RET);
      end
    end
  end

endmodule

// File: rtl/tsg_path_steer.sv
module tsg_path_steer #(
  parameter int NUM_PATHS = 3,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_in,
  input  logic                 edited,
  input  logic [SEL_W-1:0]     path_sel,
  output logic [NUM_PATHS-1:0] path_tick
);

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic hit;
    assign hit = (path_sel == SEL_W'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        path_tick[p] <= 1'b0;
      end else begin
        path_tick[p] <= hit ? edited : tick_in;
      end
    end
  end

endmodule

// File: rtl/tick_slip_gen.sv
module tick_slip_gen #(
  parameter int NUM_PATHS     = 3,
  parameter int CLKS_PER_TICK = 1000,
  parameter int INSERT_AT     = CLKS_PER_TICK / 2,
  parameter int TICKS_PER_SEC = 100000,
  localparam int SEL_W = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_in,
  input  logic [1:0]           rate_sel,
  input  logic                 adv_cmd,
  input  logic                 ret_cmd,
  input  logic [SEL_W-1:0]     path_sel,
  output logic [NUM_PATHS-1:0] path_tick
);

  logic slip_due;
  logic edited;

  tsg_rate_div #(
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_rate (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .rate_sel (rate_sel),
    .slip_due (slip_due)
  );

  tsg_edit #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .INSERT_AT    (INSERT_AT)
  ) u_edit (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .slip_due (slip_due),
    .adv_cmd  (adv_cmd),
    .ret_cmd  (ret_cmd),
    .edited   (edited)
  );

  tsg_path_steer #(
    .NUM_PATHS(NUM_PATHS),
    .SEL_W    (SEL_W)
  ) u_steer (
    .clk       (clk),
    .rst       (rst),
    .tick_in   (tick_in),
    .edited    (edited),
    .path_sel  (path_sel),
    .path_tick (path_tick)
  );

endmodule

// File: rtl/tick_slip_gen_chk.sv
module tick_slip_gen_chk #(
  parameter int NUM_PATHS = 3,
  parameter int SEL_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_in,
  input logic [SEL_W-1:0]     path_sel,
  input logic [NUM_PATHS-1:0] path_tick
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (path_tick == '0)); // R1

  AST_SINGLE_EDIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(path_tick ^ {NUM_PATHS{$past(tick_in)}}) <= 1)); // R8

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_chk
    AST_ONE_CLK_WIDE: assert property (@(posedge clk) disable iff (rst)
      path_tick[p] |=> !path_tick[p]); // R2

    AST_UNSEL_PASS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(path_sel) != SEL_W'(p)) |-> (path_tick[p] == $past(tick_in))); // R6
  end

endmodule

bind tick_slip_gen tick_slip_gen_chk #(
  .NUM_PATHS(NUM_PATHS),
  .SEL_W    (SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_in   (tick_in),
  .path_sel  (path_sel),
  .path_tick (path_tick)
);

// File: tb/tick_slip_gen_tb_top.sv
module tick_slip_gen_tb_top;

  localparam int NP  = 3;
  localparam int P   = 20;
  localparam int OFF = 10;
  localparam int TPS = 4000;

  typedef struct {
    logic [NP-1:0] vec;
    int            sel;
    string         lbl;
    string         ulbl;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_in = 1'b0;
  logic [1:0]    rate_sel = 2'd3;
  logic          adv_cmd = 1'b0;
  logic          ret_cmd = 1'b0;
  logic [1:0]    path_sel = 2'd0;
  logic [NP-1:0] path_tick;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  int   m_ticks, m_since;
  bit   m_pa, m_pr;

  always #2 clk = ~clk;

  tick_slip_gen #(
    .NUM_PATHS    (NP),
    .CLKS_PER_TICK(P),
    .INSERT_AT    (OFF),
    .TICKS_PER_SEC(TPS)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .rate_sel (rate_sel),
    .adv_cmd  (adv_cmd),
    .ret_cmd  (ret_cmd),
    .path_sel (path_sel),
    .path_tick(path_tick)
  );

  // Monitor: compare each registered result against the queued prediction.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [NP-1:0] diff;
      string tag;
      e = q.pop_front();
      n_chk++;
      diff = path_tick ^ e.vec;
      if (diff != '0) begin
        tag = e.lbl;
        for (int p = 0; p < NP; p++)
          if (diff[p] && p != e.sel) tag = e.ulbl;
        n_fail++;
        $display("FAIL %s: path_tick=%b expected=%b at %0t", tag, path_tick, e.vec, $time);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick_in = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (path_tick !== '0) begin
      n_fail++;
      $display("FAIL R1: path_tick=%b expected=%b", path_tick, {NP{1'b0}});
    end
    m_ticks = 0;
    m_since = 1000;
    m_pa = 1'b0;
    m_pr = 1'b0;
    rst = 1'b0;
  endtask

  // Driver: apply a run of ticks and push the expected output for each cycle.
  task automatic run_phase(string lbl, string ulbl, int rsel, bit a, bit r, int sel, int nticks);
    int intv;
    intv = (rsel == 0) ? TPS : (rsel == 1) ? TPS / 10 : (rsel == 2) ? TPS / 100 : TPS / 1000;
    do_reset();
    rate_sel = 2'(rsel);
    adv_cmd  = a;
    ret_cmd  = r;
    path_sel = 2'(sel);
    for (int k = 0; k < nticks * P; k++) begin
      bit tk, e, due;
      exp_t it;
      if (k != 0) @(negedge clk);
      tk = (k % P == P - 1);
      tick_in = tk;
      e = 1'b0;
      if (tk) begin
        m_ticks++;
        due = (m_ticks % intv == 0);
        e = !m_pr;
        m_pr = due && r && !a;
        if (due && a && !r) m_pa = 1'b1;
        m_since = 0;
      end else begin
        if (m_since < 1000) m_since++;
        if (m_pa && m_since == OFF) begin
          e = 1'b1;
          m_pa = 1'b0;
        end
      end
      for (int p = 0; p < NP; p++) it.vec[p] = (p == sel) ? e : tk;
      it.sel  = sel;
      it.lbl  = lbl;
      it.ulbl = ulbl;
      q.push_back(it);
    end
    @(negedge clk);
    tick_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        run_phase("R2", "R6", 3, 1'b0, 1'b0, 0, 40);
        run_phase("R3", "R6", 3, 1'b1, 1'b1, 2, 40);
        run_phase("R4", "R6", 3, 1'b1, 1'b0, 1, 40);
        run_phase("R5", "R6", 3, 1'b0, 1'b1, 2, 40);
        run_phase("R7", "R6", 2, 1'b1, 1'b0, 0, 90);
        run_phase("R7", "R6", 2, 1'b0, 1'b1, 1, 90);
        run_phase("R8", "R8", 3, 1'b1, 1'b0, 3, 20);
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule